// File: doc/BRIEF.md
# Dual-Port Serial Management Slave

This block is the slave end of a two-wire serial management bus (clock plus one bidirectional data line) with the frame layout used for 5-bit PHY and register addresses. One instance stands in for two PHY ports at adjacent addresses. Four strap inputs pick which pair of addresses the block owns. The lowest address bit of each frame steers the access to channel A or channel B. The block runs directly on the management clock and samples the data line on every rising edge. Its output driver is a registered data bit with an enable, for a tri-state pad outside the block.

A state machine hunts for a run of ones, then walks the fields of the frame: `ST_HUNT`, `ST_START`, `ST_OPCODE`, `ST_PHYAD`, `ST_REGAD`, `ST_TURN` and `ST_DATA`. The transitions are:
- `ST_HUNT`→`ST_START`: a zero arrives after at least `PRE_LEN` ones.
- `ST_START`→`ST_OPCODE`: the second start bit is one.
- `ST_OPCODE`→`ST_PHYAD`: the two opcode bits differ.
- `ST_PHYAD`→`ST_REGAD`: five address bits have arrived.
- `ST_REGAD`→`ST_TURN`: the upper PHY address bits equal the straps.
- `ST_TURN`→`ST_DATA`: the turnaround is legal.
- `ST_DATA`→`ST_HUNT`: sixteen data bits have arrived.

Every failed test on the way also returns to `ST_HUNT` with the ones count cleared.

A read raises a one-cycle request toward the two register banks outside the block and loads the returned word into a shift register. A write ends with a one-cycle strobe that carries channel, address and data. Which registers exist and which are read-only is fixed by two per-address mask parameters.

Top module: `mdio_dual_slave`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `mdio_oe`, `rd_req` and `wr_stb` are 0 and the block is hunting for a preamble. Asserting reset in the middle of a read releases the line at once.
- R2: A frame is accepted only after at least `PRE_LEN` (32) consecutive ones followed by the start bits 0 then 1. Fewer ones, or a start of 0 then 0, causes no register access and no drive.
- R3: Opcode 1,0 is a read and 0,1 is a write. Opcodes 0,0 and 1,1 abort the frame with no access and no drive.
- R4: A frame is served only when PHY address bits [4:1] equal `strap[4:1]`, and `strap[0]` has no effect. On a mismatch the line is never driven and no request or strobe is issued.
- R5: PHY address bit 0 selects the channel. Value 0 gives channel A (`rd_chan`/`wr_chan` = 0) and value 1 gives channel B (= 1).
- R6: On a read the line is released during the first turnaround bit and driven to 0 during the second. The 16 data bits follow MSB first, and the line is released after the last data bit.
- R7: `rd_req` is high for exactly one cycle, during the first turnaround bit of a matched read, with `rd_chan` and `rd_addr` valid. `rd_data` is taken in that same cycle.
- R8: A read of a register whose bit in `REG_VALID_MASK` is 0 returns 16 zeros, whatever `rd_data` holds.
- R9: A write needs turnaround 1 then 0, otherwise it is dropped. `wr_stb` is high for one cycle after the 16th data bit, with `wr_chan`, `wr_addr` and `wr_data` valid.
- R10: A write to a register that is invalid, or marked in `REG_RO_MASK`, issues no `wr_stb`.
- R11: After every completed or aborted frame a new run of at least `PRE_LEN` ones is needed before the next frame is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 5 | Address straps; bits [4:1] select the address pair, bit 0 unused |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data bit driven when enabled |
| mdio_oe | output | 1 | Output enable for the data line pad |
| rd_req | output | 1 | One-cycle register read request |
| rd_chan | output | 1 | Read channel: 0 = A, 1 = B |
| rd_addr | output | 5 | Read register address |
| rd_data | input | 16 | Read word from the selected bank, same cycle as `rd_req` |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_chan | output | 1 | Write channel: 0 = A, 1 = B |
| wr_addr | output | 5 | Write register address |
| wr_data | output | 16 | Write word |

## Verification
The bench builds the block with `PRE_LEN` of 32, `REG_VALID_MASK` of 32'h8001_00FF and `REG_RO_MASK` of 32'h0000_0006. With these values it can reach a valid register at the top address (31), a valid register far from the others (16), two read-only registers and a band of invalid addresses, all within one short run. The straps start at 5'b01011 and later change only their lowest bit, so the owned pair 10/11 stays fixed and the unused strap bit can be shown to have no effect. Neighbour addresses 12 and 14 exercise the mismatch path.

// File: rtl/mdio_dual_pkg.sv
`timescale 1ns/1ps
package mdio_dual_pkg;
    localparam int PHY_W = 5;
    localparam int REG_W = 5;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OPCODE,
        ST_PHYAD,
        ST_REGAD,
        ST_TURN,
        ST_DATA
    } mdio_state_e;
endpackage

// File: rtl/mdio_addr_check.sv
`timescale 1ns/1ps
module mdio_addr_check
    import mdio_dual_pkg::*;
#(
    parameter int                    NREG           = 1 << REG_W,
    parameter logic [NREG-1:0]       REG_VALID_MASK = '1,
    parameter logic [NREG-1:0]       REG_RO_MASK    = '0
) (
    input  logic [PHY_W-1:0] phy_ad,
    input  logic [REG_W-1:0] reg_ad,
    input  logic [PHY_W-1:0] strap,
    output logic             addr_hit,
    output logic             reg_ok,
    output logic             reg_wr_ok
);
    logic unused_strap_lsb;
    assign unused_strap_lsb = strap[0];

    // upper address bits select the pair; bit 0 picks the channel elsewhere
    assign addr_hit  = (phy_ad[PHY_W-1:1] == strap[PHY_W-1:1]);
    assign reg_ok    = REG_VALID_MASK[reg_ad];
    assign reg_wr_ok = REG_VALID_MASK[reg_ad] & ~REG_RO_MASK[reg_ad];
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_dual_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              addr_hit,
    input  logic              reg_ok,
    input  logic              reg_wr_ok,
    input  logic [DATA_W-1:0] rd_data,
    output logic [PHY_W-1:0]  phy_ad,
    output logic [REG_W-1:0]  reg_ad,
    output logic              rd_req,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              drv_en,
    output logic              drv_bit
);
    localparam int CNT_MAX = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] PRE_TOP  = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] DATA_TOP = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] PHY_TOP  = CNT_W'(PHY_W - 1);
    localparam logic [CNT_W-1:0] REG_TOP  = CNT_W'(REG_W - 1);

    mdio_state_e       state, state_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic              is_rd;
    logic [DATA_W-2:0] rx;
    logic [DATA_W-1:0] tx;

    // next state and bit counter
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_HUNT: begin
                if (bit_in) begin
                    cnt_nx = (cnt == PRE_TOP) ? cnt : cnt + 1'b1;
                end else if (cnt == PRE_TOP) begin
                    state_nx = ST_START;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = '0;
                end
            end
            ST_START: begin
                cnt_nx   = '0;
                state_nx = bit_in ? ST_OPCODE : ST_HUNT;
            end
            ST_OPCODE: begin
                if (cnt == '0) begin
                    cnt_nx = 1'b1;
                end else begin
                    cnt_nx   = '0;
                    state_nx = (bit_in != is_rd) ? ST_PHYAD : ST_HUNT;
                end
            end
            ST_PHYAD: begin
                if (cnt == PHY_TOP) begin
                    cnt_nx   = '0;
                    state_nx = ST_REGAD;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_REGAD: begin
                if (cnt == REG_TOP) begin
                    cnt_nx   = '0;
                    state_nx = addr_hit ? ST_TURN : ST_HUNT;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_TURN: begin
                if (cnt == '0) begin
                    if (!is_rd && !bit_in) state_nx = ST_HUNT;
                    else                   cnt_nx   = 1'b1;
                end else begin
                    cnt_nx   = '0;
                    state_nx = (!is_rd && bit_in) ? ST_HUNT : ST_DATA;
                end
            end
            ST_DATA: begin
                if (cnt == DATA_TOP) begin
                    cnt_nx   = '0;
                    state_nx = ST_HUNT;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                cnt_nx   = '0;
                state_nx = ST_HUNT;
            end
        endcase
    end

    // state register and field capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_HUNT;
            cnt    <= '0;
            is_rd  <= 1'b0;
            phy_ad <= '0;
            reg_ad <= '0;
            rx     <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            unique case (state)
                ST_OPCODE: if (cnt == '0) is_rd <= bit_in;
                ST_PHYAD:  phy_ad <= {phy_ad[PHY_W-2:0], bit_in};
                ST_REGAD:  reg_ad <= {reg_ad[REG_W-2:0], bit_in};
                ST_DATA:   rx     <= {rx[DATA_W-3:0], bit_in};
                default:   ;
            endcase
        end
    end

    assign rd_req = (state == ST_TURN) && (cnt == '0) && is_rd;

    // output driver and write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_en  <= 1'b0;
            drv_bit <= 1'b0;
            tx      <= '0;
            wr_stb  <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            unique case (state)
                ST_TURN: begin
                    if (is_rd) begin
                        if (cnt == '0) begin
                            drv_en  <= 1'b1;
                            drv_bit <= 1'b0;
                            tx      <= reg_ok ? rd_data : '0;
                        end else begin
                            drv_bit <= tx[DATA_W-1];
                            tx      <= {tx[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                ST_DATA: begin
                    if (is_rd) begin
                        if (cnt == DATA_TOP) begin
                            drv_en  <= 1'b0;
                            drv_bit <= 1'b0;
                        end else begin
                            drv_bit <= tx[DATA_W-1];
                            tx      <= {tx[DATA_W-2:0], 1'b0};
                        end
                    end else if (cnt == DATA_TOP) begin
                        wr_stb  <= reg_wr_ok;
                        wr_data <= {rx, bit_in};
                    end
                end
                default: begin
                    drv_en  <= 1'b0;
                    drv_bit <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/mdio_dual_slave.sv
`timescale 1ns/1ps
module mdio_dual_slave
    import mdio_dual_pkg::*;
#(
    parameter int                    PRE_LEN        = 32,
    parameter int                    DATA_W         = 16,
    parameter logic [(1<<REG_W)-1:0] REG_VALID_MASK = 32'h0001_FFFF,
    parameter logic [(1<<REG_W)-1:0] REG_RO_MASK    = 32'h0000_000C
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [PHY_W-1:0]  strap,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_req,
    output logic              rd_chan,
    output logic [REG_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_stb,
    output logic              wr_chan,
    output logic [REG_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic [PHY_W-1:0] phy_ad;
    logic [REG_W-1:0] reg_ad;
    logic             addr_hit, reg_ok, reg_wr_ok;

    mdio_addr_check #(
        .NREG           (1 << REG_W),
        .REG_VALID_MASK (REG_VALID_MASK),
        .REG_RO_MASK    (REG_RO_MASK)
    ) u_check (
        .phy_ad    (phy_ad),
        .reg_ad    (reg_ad),
        .strap     (strap),
        .addr_hit  (addr_hit),
        .reg_ok    (reg_ok),
        .reg_wr_ok (reg_wr_ok)
    );

    mdio_frame_fsm #(
        .PRE_LEN (PRE_LEN),
        .DATA_W  (DATA_W)
    ) u_fsm (
        .clk       (mdc),
        .rst_n     (rst_n),
        .bit_in    (mdio_i),
        .addr_hit  (addr_hit),
        .reg_ok    (reg_ok),
        .reg_wr_ok (reg_wr_ok),
        .rd_data   (rd_data),
        .phy_ad    (phy_ad),
        .reg_ad    (reg_ad),
        .rd_req    (rd_req),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .drv_en    (mdio_oe),
        .drv_bit   (mdio_o)
    );

    assign rd_chan = phy_ad[0];
    assign wr_chan = phy_ad[0];
    assign rd_addr = reg_ad;
    assign wr_addr = reg_ad;
endmodule

// File: rtl/mdio_dual_slave_chk.sv
`timescale 1ns/1ps
module mdio_dual_slave_chk #(
    parameter int DATA_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic mdio_oe,
    input logic mdio_o,
    input logic rd_req,
    input logic wr_stb
);
    logic [7:0] oe_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            oe_run <= '0;
        else if (!mdio_oe)     oe_run <= '0;
        else if (oe_run != '1) oe_run <= oe_run + 1'b1;
    end

    a_r9_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    a_r7_req_stb_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_stb));

    a_r6_ta_zero_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> (!mdio_o && $past(rd_req)));

    a_r6_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        oe_run <= 8'(DATA_W + 1));

    a_r9_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !mdio_oe);
endmodule

bind mdio_dual_slave mdio_dual_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (mdc),
    .rst_n   (rst_n),
    .mdio_oe (mdio_oe),
    .mdio_o  (mdio_o),
    .rd_req  (rd_req),
    .wr_stb  (wr_stb)
);

// File: tb/mdio_dual_slave_tb_top.sv
`timescale 1ns/1ps
module mdio_dual_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap = 5'b01011;
    logic        m_en = 1'b0;
    logic        m_bit = 1'b1;
    logic        mdio_i, mdio_o, mdio_oe;
    logic        rd_req, rd_chan, wr_stb, wr_chan;
    logic [4:0]  rd_addr, wr_addr;
    logic [15:0] rd_data, wr_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (m_en ? m_bit : 1'b1);

    mdio_dual_slave #(
        .PRE_LEN        (32),
        .DATA_W         (16),
        .REG_VALID_MASK (32'h8001_00FF),
        .REG_RO_MASK    (32'h0000_0006)
    ) dut_i (
        .mdc     (clk),
        .rst_n   (rst_n),
        .strap   (strap),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_req  (rd_req),
        .rd_chan (rd_chan),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_stb  (wr_stb),
        .wr_chan (wr_chan),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // two register banks
    logic [15:0] bank_a [32];
    logic [15:0] bank_b [32];
    assign rd_data = rd_chan ? bank_b[rd_addr] : bank_a[rd_addr];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin
                bank_a[i] = 16'hA000 | 16'(i);
                bank_b[i] = 16'hB000 | 16'(i);
            end
        end else if (wr_stb) begin
            if (wr_chan) bank_b[wr_addr] = wr_data;
            else         bank_a[wr_addr] = wr_data;
        end
    end

    // port monitors
    int          oe_cnt, req_cnt, stb_cnt;
    logic        cap_rchan, cap_wchan;
    logic [4:0]  cap_raddr, cap_waddr;
    logic [15:0] cap_wdata;

    always @(negedge clk) begin
        if (mdio_oe) oe_cnt++;
        if (rd_req) begin
            req_cnt++;
            cap_rchan = rd_chan;
            cap_raddr = rd_addr;
        end
        if (wr_stb) begin
            stb_cnt++;
            cap_wchan = wr_chan;
            cap_waddr = wr_addr;
            cap_wdata = wr_data;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk);
        m_en  = 1'b1;
        m_bit = b;
    endtask

    task automatic run_frame(input int npre, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] ra,
                             input logic [1:0] ta, input logic [15:0] wd,
                             output logic [15:0] rv, output logic t1,
                             output logic t2, output logic rel);
        oe_cnt = 0; req_cnt = 0; stb_cnt = 0;
        rv = '0; t1 = 1'b0; t2 = 1'b0;
        for (int i = 0; i < npre; i++) put_bit(1'b1);
        put_bit(st[1]); put_bit(st[0]);
        put_bit(op[1]); put_bit(op[0]);
        for (int i = 4; i >= 0; i--) put_bit(phy[i]);
        for (int i = 4; i >= 0; i--) put_bit(ra[i]);
        if (op == 2'b10) begin
            @(negedge clk); m_en = 1'b0; t1 = mdio_oe;
            @(negedge clk); t2 = mdio_oe && !mdio_o;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                rv = {rv[14:0], mdio_oe ? mdio_o : 1'b1};
            end
            @(negedge clk);
            rel = !mdio_oe;
        end else begin
            put_bit(ta[1]); put_bit(ta[0]);
            for (int i = 15; i >= 0; i--) put_bit(wd[i]);
            @(negedge clk); m_en = 1'b0;
            @(negedge clk);
            @(negedge clk);
            rel = !mdio_oe;
        end
    endtask

    // stimulus table: {read, served, phy, reg, data/expected}
    localparam int NV = 16;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 1'b1, 5'h0A, 5'd3,  16'hA003},
        {1'b1, 1'b1, 5'h0B, 5'd3,  16'hB003},
        {1'b0, 1'b1, 5'h0A, 5'd4,  16'h1234},
        {1'b1, 1'b1, 5'h0A, 5'd4,  16'h1234},
        {1'b1, 1'b1, 5'h0B, 5'd4,  16'hB004},
        {1'b0, 1'b1, 5'h0B, 5'd31, 16'hBEEF},
        {1'b1, 1'b1, 5'h0B, 5'd31, 16'hBEEF},
        {1'b0, 1'b0, 5'h0A, 5'd1,  16'h5555},
        {1'b1, 1'b1, 5'h0A, 5'd1,  16'hA001},
        {1'b0, 1'b0, 5'h0A, 5'd9,  16'h7777},
        {1'b1, 1'b1, 5'h0A, 5'd9,  16'h0000},
        {1'b1, 1'b0, 5'h0C, 5'd3,  16'h0000},
        {1'b0, 1'b0, 5'h0E, 5'd5,  16'h0000},
        {1'b1, 1'b1, 5'h0A, 5'd16, 16'hA010},
        {1'b0, 1'b1, 5'h0A, 5'd0,  16'hFFFF},
        {1'b1, 1'b1, 5'h0A, 5'd0,  16'hFFFF}
    };

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        logic t1, t2, rel;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!mdio_oe && !rd_req && !wr_stb, "R1 reset", {mdio_oe, rd_req, wr_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mdio_oe && !rd_req && !wr_stb, "R1 after reset", {mdio_oe, rd_req, wr_stb}, 0);

        for (int v = 0; v < NV; v++) begin
            logic        rd, srv;
            logic [4:0]  phy, ra;
            logic [15:0] d;
            {rd, srv, phy, ra, d} = VEC[v];
            if (rd) begin
                run_frame(32, 2'b01, 2'b10, phy, ra, 2'b10, 16'h0, rv, t1, t2, rel);
                if (srv) begin
                    check(rv == d, (d == 16'h0) ? "R8 invalid read zero" : "R6 read data",
                          rv, d);
                    check(!t1 && t2 && rel, "R6 turnaround/release", {t1, t2, rel}, 3'b011);
                    check(req_cnt == 1 && cap_raddr == ra, "R7 read request",
                          {req_cnt[7:0], 3'b0, cap_raddr}, {8'd1, 3'b0, ra});
                    check(cap_rchan == phy[0], "R5 read channel", cap_rchan, phy[0]);
                end else begin
                    check(oe_cnt == 0 && req_cnt == 0, "R4 mismatch read silent",
                          {oe_cnt[15:0], req_cnt[15:0]}, 0);
                end
            end else begin
                run_frame(32, 2'b01, 2'b01, phy, ra, 2'b10, d, rv, t1, t2, rel);
                if (srv) begin
                    check(stb_cnt == 1 && cap_waddr == ra && cap_wdata == d,
                          "R9 write strobe", {stb_cnt[7:0], 3'b0, cap_waddr, cap_wdata},
                          {8'd1, 3'b0, ra, d});
                    check(cap_wchan == phy[0], "R5 write channel", cap_wchan, phy[0]);
                end else begin
                    check(stb_cnt == 0 && oe_cnt == 0,
                          (phy[4:1] == strap[4:1]) ? "R10 write dropped" : "R4 mismatch write",
                          {stb_cnt[15:0], oe_cnt[15:0]}, 0);
                end
            end
        end

        // R2: 31 ones only
        put_bit(1'b0);
        run_frame(31, 2'b01, 2'b10, 5'h0A, 5'd3, 2'b10, 16'h0, rv, t1, t2, rel);
        check(oe_cnt == 0 && req_cnt == 0, "R2 short preamble", {oe_cnt[15:0], req_cnt[15:0]}, 0);

        // R2: bad start bits
        run_frame(32, 2'b00, 2'b01, 5'h0A, 5'd4, 2'b10, 16'h0BAD, rv, t1, t2, rel);
        check(stb_cnt == 0 && oe_cnt == 0, "R2 bad start", {stb_cnt[15:0], oe_cnt[15:0]}, 0);

        // R3: illegal opcodes
        run_frame(32, 2'b01, 2'b11, 5'h0A, 5'd3, 2'b10, 16'h0, rv, t1, t2, rel);
        check(oe_cnt == 0 && req_cnt == 0 && stb_cnt == 0, "R3 opcode 11",
              {oe_cnt[7:0], req_cnt[7:0], stb_cnt[7:0]}, 0);
        put_bit(1'b0);
        run_frame(32, 2'b01, 2'b00, 5'h0A, 5'd4, 2'b10, 16'h0, rv, t1, t2, rel);
        check(oe_cnt == 0 && req_cnt == 0 && stb_cnt == 0, "R3 opcode 00",
              {oe_cnt[7:0], req_cnt[7:0], stb_cnt[7:0]}, 0);

        // R9: bad write turnaround
        put_bit(1'b0);
        run_frame(32, 2'b01, 2'b01, 5'h0A, 5'd4, 2'b00, 16'h0, rv, t1, t2, rel);
        check(stb_cnt == 0, "R9 bad turnaround", stb_cnt, 0);
        run_frame(32, 2'b01, 2'b10, 5'h0A, 5'd4, 2'b10, 16'h0, rv, t1, t2, rel);
        check(rv == 16'h1234, "R9 register kept after bad turnaround", rv, 16'h1234);

        // R11: frame without fresh preamble
        run_frame(0, 2'b01, 2'b10, 5'h0A, 5'd3, 2'b10, 16'h0, rv, t1, t2, rel);
        check(oe_cnt == 0 && req_cnt == 0, "R11 no preamble", {oe_cnt[15:0], req_cnt[15:0]}, 0);
        run_frame(32, 2'b01, 2'b10, 5'h0A, 5'd3, 2'b10, 16'h0, rv, t1, t2, rel);
        check(rv == 16'hA003 && req_cnt == 1, "R11 resync after preamble", rv, 16'hA003);

        // R4: strap bit 0 has no effect
        strap = 5'b01010;
        run_frame(32, 2'b01, 2'b10, 5'h0B, 5'd3, 2'b10, 16'h0, rv, t1, t2, rel);
        check(rv == 16'hB003 && cap_rchan, "R4 strap lsb ignored", rv, 16'hB003);

        // R1: reset during read data
        oe_cnt = 0;
        for (int i = 0; i < 32; i++) put_bit(1'b1);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        for (int i = 4; i >= 0; i--) put_bit(5'h0A >> i);
        for (int i = 4; i >= 0; i--) put_bit(5'd3 >> i);
        @(negedge clk); m_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(mdio_oe == 1'b1, "R1 driving before reset", mdio_oe, 1);
        rst_n = 1'b0;
        #1;
        check(!mdio_oe && !rd_req && !wr_stb, "R1 reset mid-read", {mdio_oe, rd_req, wr_stb}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule